// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Pipeline

This block adds or subtracts two binary32 floating-point words. The word is laid out as a sign bit at the top, then an 8-bit biased exponent (bias 127), then a 23-bit fraction. A new operand pair, with a subtract selector, may be presented on every clock. Each pair is marked by an input valid strobe. Its result comes out exactly four cycles later, together with an output valid strobe and three status flags. A pair is never stalled and never dropped.

Internally the work passes through four register stages. The first lines up the operand of lesser magnitude against the larger one and keeps guard, round and sticky bits. The second adds or subtracts the significands. The third normalizes the sum, whether it carried out or cancelled. The fourth rounds to nearest with ties to even and renormalizes if rounding carries. Special encodings are recognised on entry and forced onto the output:

- An exponent field of zero is a subnormal with no hidden bit and an effective exponent of 1 minus the bias.
- An all-ones exponent is an infinity when the fraction is zero and a NaN when it is not.

Top module: `fp32_addsub`

## Requirements
- R1: For finite operands, `result` is the sum opA + opB rounded once to nearest, ties to even. A normal operand carries an implicit leading 1 ahead of its 23-bit fraction (bits 22:0), and its exponent sits in bits 30:23 with bias 127.
- R2: With `subtract` high, the block returns opA − opB, which is the sum with the sign bit (bit 31) of opB inverted.
- R3: When the exponents differ, the smaller operand's bits that fall below the result's precision still decide the rounding. Exactly half an ulp rounds to the even neighbour. Anything above half rounds up. A tiny addend leaves the larger operand unchanged.
- R4: A sum that loses leading bits through cancellation is renormalized: 0x3F000000 + 0xBEE00000 gives 0x3D800000.
- R5: An exact zero from operands of opposite effective sign is +0 (0x00000000). Two zeros of equal sign keep that sign, so −0 + −0 gives 0x80000000.
- R6: Subnormal operands (exponent field 0) are handled exactly. `underflow` is high with a valid result exactly when the result's exponent field is 0 and its fraction is nonzero.
- R7: A finite result whose rounded exponent reaches 255 becomes an infinity of the result's sign (exponent all ones, fraction 0) and raises `overflow`. At most one flag is ever high.
- R8: A NaN operand (exponent 255, fraction ≠ 0), or the effective sum of two infinities of opposite sign, gives 0x7FC00000 and raises `invalid`.
- R9: An infinity plus a finite value, or plus an infinity of the same sign, returns that infinity with all flags low.
- R10: `outValid` equals `inValid` delayed by exactly four clocks. One pair may enter on every clock, back to back.
- R11: While `rst` is high and on the first cycles after it, `outValid` is low.
- R12: When rounding carries out of the significand, the exponent increments: 0x3FFFFFFF + 0x33800000 gives 0x40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| inValid | input | 1 | Operand pair present this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subtract | input | 1 | High: opA − opB; low: opA + opB |
| outValid | output | 1 | Result present this cycle |
| result | output | 32 | Rounded sum or difference |
| overflow | output | 1 | Finite operands produced an infinity |
| underflow | output | 1 | Result is subnormal and nonzero |
| invalid | output | 1 | Result is the default quiet NaN |

## Verification
The bench builds the block with its default exponent width of 8 and fraction width of 23. Under those parameters the reference model can hold every finite operand as an exact integer multiple of the smallest subnormal, in fewer than 290 bits. This puts the full exponent range within reach of a single exact sum and one rounding step. The cases covered are subnormal-only sums, carries into the largest exponent, and alignment shifts far past the guard bits. The directed cases hit the tie, cancellation and special-value corners. Operand pairs drawn with nearby exponents run back to back and with random gaps, so the latency and overlap are exercised on every cycle.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int STAGES = 4;

  // Per-stage strobes from control to datapath.
  typedef struct packed {
    logic [STAGES-1:0] load;  // stage k captures new data this cycle
    logic [STAGES-1:0] hold;  // stage k currently holds a valid pair
  } fpaStrobe_t;

endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output fpaStrobe_t strobe,
  output logic       outValid
);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  assign strobe.load = {validPipe[STAGES-2:0], inValid};
  assign strobe.hold = validPipe;
  assign outValid    = validPipe[STAGES-1];

  // R10: a pair entering is held by the first stage on the next clock
  p_valid_enter_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> validPipe[0]);

  // R10: no phantom pair appears at the output stage
  p_valid_chain_r10: assert property (@(posedge clk) disable iff (rst)
    !validPipe[STAGES-2] |=> !outValid);

endmodule

// File: rtl/fpadd_datapath.sv
module fpadd_datapath
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fpaStrobe_t              strobe,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  input  logic                    subtract,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    overflow,
  output logic                    underflow,
  output logic                    invalid
);

  localparam int WW   = EXP_W + FRAC_W + 1;  // word width
  localparam int MW   = FRAC_W + 1;          // significand with hidden bit
  localparam int XW   = MW + 3;              // plus guard, round, sticky
  localparam int SW   = XW + 1;              // plus carry
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int LZW  = $clog2(XW + 1);
  localparam logic [WW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [LZW-1:0] leadZeros(input logic [XW-1:0] v);
    leadZeros = LZW'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) leadZeros = LZW'(XW - 1 - i);
  endfunction

  // ---------------- stage 1: unpack, order, align ----------------
  logic              aSign, bSign, aNan, bNan, aInf, bInf, aBigger;
  logic [EXP_W-1:0]  aExp, bExp, bigExp, smlExp, bigEff, smlEff, expDiff;
  logic [FRAC_W-1:0] aFrac, bFrac, bigFrac, smlFrac;
  logic              bigSign;
  logic [XW-1:0]     smlExt, smlAligned;
  logic              alignSticky;

  always_comb begin
    aSign   = opA[WW-1];
    bSign   = opB[WW-1] ^ subtract;
    aExp    = opA[FRAC_W +: EXP_W];
    bExp    = opB[FRAC_W +: EXP_W];
    aFrac   = opA[FRAC_W-1:0];
    bFrac   = opB[FRAC_W-1:0];
    aNan    = (&aExp) && (|aFrac);
    bNan    = (&bExp) && (|bFrac);
    aInf    = (&aExp) && !(|aFrac);
    bInf    = (&bExp) && !(|bFrac);
    aBigger = opA[WW-2:0] >= opB[WW-2:0];
    bigExp  = aBigger ? aExp  : bExp;
    bigFrac = aBigger ? aFrac : bFrac;
    bigSign = aBigger ? aSign : bSign;
    smlExp  = aBigger ? bExp  : aExp;
    smlFrac = aBigger ? bFrac : aFrac;
    bigEff  = (bigExp == '0) ? EXP_W'(1) : bigExp;
    smlEff  = (smlExp == '0) ? EXP_W'(1) : smlExp;
    expDiff = bigEff - smlEff;
    smlExt  = {(smlExp != '0), smlFrac, 3'b000};
    if (int'(expDiff) >= XW) begin
      smlAligned  = '0;
      alignSticky = |smlExt;
    end else begin
      smlAligned  = smlExt >> expDiff;
      alignSticky = |(smlExt & ~({XW{1'b1}} << expDiff));
    end
    smlAligned[0] = smlAligned[0] | alignSticky;
  end

  logic             s1Sign, s1Sub, s1Nan, s1Inf, s1InfSign;
  logic [EXP_W-1:0] s1Exp;
  logic [XW-1:0]    s1Big, s1Sml;

  always_ff @(posedge clk) begin
    if (strobe.load[0]) begin
      s1Sign    <= bigSign;
      s1Sub     <= aSign ^ bSign;
      s1Exp     <= bigEff;
      s1Big     <= {(bigExp != '0), bigFrac, 3'b000};
      s1Sml     <= smlAligned;
      s1Nan     <= aNan | bNan | (aInf & bInf & (aSign != bSign));
      s1Inf     <= aInf | bInf;
      s1InfSign <= aInf ? aSign : bSign;
    end
  end

  // ---------------- stage 2: significand add ----------------
  logic [SW-1:0] sumComb;
  assign sumComb = s1Sub ? ({1'b0, s1Big} - {1'b0, s1Sml})
                         : ({1'b0, s1Big} + {1'b0, s1Sml});

  logic             s2Sign, s2Nan, s2Inf, s2InfSign;
  logic [EXP_W-1:0] s2Exp;
  logic [SW-1:0]    s2Sum;

  always_ff @(posedge clk) begin
    if (strobe.load[1]) begin
      s2Sum     <= sumComb;
      s2Sign    <= (s1Sub && sumComb == '0) ? 1'b0 : s1Sign;
      s2Exp     <= s1Exp;
      s2Nan     <= s1Nan;
      s2Inf     <= s1Inf;
      s2InfSign <= s1InfSign;
    end
  end

  // ---------------- stage 3: normalize ----------------
  logic [LZW-1:0]   lzCount;
  logic [EXP_W:0]   shiftLim, shiftAmt, normExp;
  logic [XW-1:0]    normSig;

  always_comb begin
    lzCount  = leadZeros(s2Sum[XW-1:0]);
    shiftLim = {1'b0, s2Exp} - (EXP_W+1)'(1);
    shiftAmt = ((EXP_W+1)'(lzCount) < shiftLim) ? (EXP_W+1)'(lzCount) : shiftLim;
    if (s2Sum[SW-1]) begin
      normSig = {s2Sum[SW-1:2], s2Sum[1] | s2Sum[0]};
      normExp = {1'b0, s2Exp} + (EXP_W+1)'(1);
    end else begin
      normSig = s2Sum[XW-1:0] << shiftAmt;
      normExp = {1'b0, s2Exp} - shiftAmt;
    end
  end

  logic             s3Sign, s3Nan, s3Inf, s3InfSign;
  logic [EXP_W:0]   s3Exp;
  logic [XW-1:0]    s3Sig;

  always_ff @(posedge clk) begin
    if (strobe.load[2]) begin
      s3Sig     <= normSig;
      s3Exp     <= normExp;
      s3Sign    <= s2Sign;
      s3Nan     <= s2Nan;
      s3Inf     <= s2Inf;
      s3InfSign <= s2InfSign;
    end
  end

  // R4: a normalized nonzero significand above the subnormal floor leads with 1
  p_norm_lead_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.hold[2] && s3Exp > (EXP_W+1)'(1) && (|s3Sig)) |-> s3Sig[XW-1]);

  // ---------------- stage 4: round, renormalize, pack ----------------
  logic [MW-1:0]     keepSig, finalSig;
  logic [MW:0]       roundSum;
  logic              roundUp, isOvf;
  logic [EXP_W:0]    finalExp;
  logic [EXP_W-1:0]  expField;
  logic [WW-1:0]     packed_;
  logic              ovfNext, unfNext, invNext;

  always_comb begin
    keepSig  = s3Sig[XW-1:3];
    roundUp  = s3Sig[2] & (s3Sig[1] | s3Sig[0] | keepSig[0]);
    roundSum = {1'b0, keepSig} + (MW+1)'(roundUp);
    if (roundSum[MW]) begin
      finalSig = roundSum[MW:1];
      finalExp = s3Exp + (EXP_W+1)'(1);
    end else begin
      finalSig = roundSum[MW-1:0];
      finalExp = s3Exp;
    end
    expField = finalSig[MW-1] ? finalExp[EXP_W-1:0] : '0;
    isOvf    = finalExp >= (EXP_W+1)'(EMAX);
    ovfNext  = 1'b0;
    unfNext  = 1'b0;
    invNext  = 1'b0;
    if (s3Nan) begin
      packed_ = QNAN;
      invNext = 1'b1;
    end else if (s3Inf) begin
      packed_ = {s3InfSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (isOvf) begin
      packed_ = {s3Sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovfNext = 1'b1;
    end else begin
      packed_ = {s3Sign, expField, finalSig[FRAC_W-1:0]};
      unfNext = (expField == '0) && (|finalSig);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load[3]) begin
      result    <= packed_;
      overflow  <= ovfNext;
      underflow <= unfNext;
      invalid   <= invNext;
    end
  end

  // R8: the invalid flag travels only with the default quiet NaN
  p_nan_code_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.hold[3] && invalid) |-> (result == QNAN));

  // R7: overflow always yields an infinity encoding
  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.hold[3] && overflow) |-> (result[WW-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  // R6: underflow only with a zero exponent field and nonzero fraction
  p_unf_field_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.hold[3] && underflow) |-> (result[FRAC_W +: EXP_W] == '0 && (|result[FRAC_W-1:0])));

  // R7: flags are mutually exclusive
  p_flag_excl_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.hold[3] |-> $countones({overflow, underflow, invalid}) <= 1);

endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                  subtract,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  overflow,
  output logic                  underflow,
  output logic                  invalid
);

  fpaStrobe_t strobe;

  fpadd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fpadd_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .subtract  (subtract),
    .result    (result),
    .overflow  (overflow),
    .underflow (underflow),
    .invalid   (invalid)
  );

endmodule

// File: tb/test_fp32_addsub.sv
`timescale 1ns/1ps
module test_fp32_addsub;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        subtract = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic        overflow, underflow, invalid;

  always #2 clk = ~clk;  // 250 MHz

  fp32_addsub i_fp32_addsub (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .subtract(subtract), .outValid(outValid), .result(result),
    .overflow(overflow), .underflow(underflow), .invalid(invalid)
  );

  typedef struct {
    bit          vld;
    logic [31:0] res;
    bit          ovf, unf, inv;
    string       tag;
  } expect_t;

  expect_t pend[$];
  int total = 0;
  int bad   = 0;

  // Exact reference: finite values become integers in units of 2^-149.
  function automatic expect_t refAdd(logic [31:0] a, logic [31:0] b, bit sub);
    expect_t     e;
    bit          sa, sb, sr, half, stick, up;
    logic [7:0]  ea, eb;
    logic [22:0] fa, fb;
    logic [289:0] ma, mb, m, mask;
    logic [24:0] keep;
    int          p, sh, ex;
    e.vld = 1; e.ovf = 0; e.unf = 0; e.inv = 0; e.tag = "";
    sa = a[31]; sb = b[31] ^ sub;
    ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0) ||
        (ea == 8'hFF && eb == 8'hFF && sa != sb)) begin
      e.res = 32'h7FC00000; e.inv = 1; return e;
    end
    if (ea == 8'hFF) begin e.res = {sa, 8'hFF, 23'd0}; return e; end
    if (eb == 8'hFF) begin e.res = {sb, 8'hFF, 23'd0}; return e; end
    ma = (ea == 0) ? 290'(fa) : (290'({1'b1, fa}) << (ea - 1));
    mb = (eb == 0) ? 290'(fb) : (290'({1'b1, fb}) << (eb - 1));
    if (sa == sb) begin m = ma + mb; sr = sa; end
    else if (ma >= mb) begin m = ma - mb; sr = (m == 0) ? 1'b0 : sa; end
    else begin m = mb - ma; sr = sb; end
    if (m == 0) begin e.res = {sr, 31'd0}; return e; end
    p = 0;
    for (int i = 0; i < 290; i++) if (m[i]) p = i;
    if (p < 24) begin
      e.res = {sr, m[30:0]};
      e.unf = (m[23] == 1'b0);
      return e;
    end
    sh    = p - 23;
    keep  = 25'(m >> sh);
    half  = m[sh-1];
    mask  = ~({290{1'b1}} << (sh - 1));
    stick = |(m & mask);
    up    = half & (stick | keep[0]);
    keep  = keep + 25'(up);
    ex    = sh + 1;
    if (keep[24]) begin keep = keep >> 1; ex++; end
    if (ex >= 255) begin e.res = {sr, 8'hFF, 23'd0}; e.ovf = 1; end
    else e.res = {sr, 8'(ex), keep[22:0]};
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: compare the oldest pending entry, then drive.
  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input bit s, input string tag);
    expect_t e, x;
    if (pend.size() == 4) begin
      x = pend.pop_front();
      check(outValid == x.vld, "R10", "outValid", 64'(outValid), 64'(x.vld));
      if (x.vld && outValid)
        check({result, overflow, underflow, invalid} == {x.res, x.ovf, x.unf, x.inv},
              x.tag, "result/ovf/unf/inv",
              {29'd0, result, overflow, underflow, invalid},
              {29'd0, x.res, x.ovf, x.unf, x.inv});
    end
    inValid = v; opA = a; opB = b; subtract = s;
    if (v) begin e = refAdd(a, b, s); e.tag = tag; end
    else begin e.vld = 0; e.res = '0; e.ovf = 0; e.unf = 0; e.inv = 0; e.tag = "R10"; end
    pend.push_back(e);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    expect_t idle;
    idle.vld = 0; idle.res = '0; idle.ovf = 0; idle.unf = 0; idle.inv = 0; idle.tag = "R11";
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11", "outValid in reset", 64'(outValid), 64'd0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) pend.push_back(idle);  // post-reset cycles: R11

    step(1, 32'h3F800000, 32'h3F800000, 0, "R1");
    step(1, 32'h3FC00000, 32'h40100000, 0, "R1");
    step(1, 32'h40A00000, 32'h3F800000, 1, "R2");
    step(1, 32'h3F800000, 32'hC0000000, 1, "R2");
    step(1, 32'h3F000000, 32'hBEE00000, 0, "R4");
    step(1, 32'h3F800000, 32'h3F7FFFFF, 1, "R4");
    step(1, 32'h3F800000, 32'h33800000, 0, "R3");
    step(1, 32'h3F800001, 32'h33800000, 0, "R3");
    step(1, 32'h3F800000, 32'h33800001, 0, "R3");
    step(1, 32'h3F800000, 32'h00000001, 0, "R3");
    step(1, 32'h3FFFFFFF, 32'h33800000, 0, "R12");
    step(1, 32'h3F800000, 32'h3F800000, 1, "R5");
    step(1, 32'h80000000, 32'h80000000, 0, "R5");
    step(1, 32'h00000000, 32'h80000000, 0, "R5");
    step(1, 32'h00000001, 32'h00000001, 0, "R6");
    step(1, 32'h00800000, 32'h00000001, 1, "R6");
    step(1, 32'h00400000, 32'h00400000, 0, "R6");
    step(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, "R7");
    step(1, 32'hFF7FFFFF, 32'hFF000000, 0, "R7");
    step(1, 32'h7FC00000, 32'h3F800000, 0, "R8");
    step(1, 32'h00000000, 32'h7F800001, 0, "R8");
    step(1, 32'h7F800000, 32'hFF800000, 0, "R8");
    step(1, 32'h7F800000, 32'h7F800000, 1, "R8");
    step(1, 32'h7F800000, 32'h3F800000, 0, "R9");
    step(1, 32'h3F800000, 32'hFF800000, 0, "R9");
    step(1, 32'hFF800000, 32'hFF800000, 0, "R9");

    // Directed value check of the cancellation case, independent of the model.
    for (int i = 0; i < 4; i++) step(0, '0, '0, 0, "R10");
    step(1, 32'h3F000000, 32'hBEE00000, 0, "R4");
    for (int i = 0; i < 3; i++) step(0, '0, '0, 0, "R10");
    check(outValid && result == 32'h3D800000, "R4", "cancel 0.5-0.4375",
          64'(result), 64'h3D800000);

    // Random pairs with nearby exponents, back to back and with gaps.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      int d;
      a = $urandom;
      b = $urandom;
      d = int'(a[30:23]) + ($urandom % 61) - 30;
      if (d < 0) d = 0;
      if (d > 254) d = 254;
      b[30:23] = 8'(d);
      step(($urandom % 5) != 0, a, b, bit'($urandom % 2), "R1");
    end
    for (int i = 0; i < 6; i++) step(0, '0, '0, 0, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule